// File: doc/BRIEF.md
# ECC Error Status Register File

This block collects error reports from an ECC decoder and holds them where software can reach them over a small memory-mapped slave port. Each cycle the decoder may signal a correctable (single-bit) error, an uncorrectable (double-bit) error, or both, together with the address of the access that produced them. The block keeps a sticky flag for each error type, a 4-bit event count for each type, the address of the most recent erroneous access, and an interrupt status that drives an interrupt output.

Software polls or takes the interrupt, reads the registers and clears them. Writing a one to bit 0 of the status word clears both flags and the interrupt. Writing anything to a count register zeroes that count. The counts are deliberately narrow and wrap around instead of saturating, so software that needs a long-running total must read them often enough.

Top module: `ecc_err_status`

## Requirements
- R1: After reset the flags, interrupt, both counts and the stored address are zero, `irq` is low and `regRdValid` is low.
- R2: The status word at offset 0x0 holds the single-bit flag in bit 0, the double-bit flag in bit 1 and the interrupt status in bit 2. An event of either type sets its flag and the interrupt status, and `irq` follows the interrupt status one cycle after the event.
- R3: The single-bit count at offset 0x4, read in bits 3:0, rises by one for each cycle with `sbeEvt` high and goes from 15 back to 0 on the sixteenth event.
- R4: The double-bit count at offset 0x8, read in bits 3:0, counts `dbeEvt` cycles in the same way, independently of the single-bit count.
- R5: On any cycle with an event, `errAddr` is stored and read back at offset 0xC. When both event types arrive in one cycle, both counts rise by one and the address is stored once.
- R6: A write to offset 0x0 with bit 0 of `regWdata` set clears both flags and the interrupt status. A write there with bit 0 clear changes nothing. An event in the same cycle as a clear leaves its flag and the interrupt status set.
- R7: A write to offset 0x4 or 0x8 zeroes that count whatever the data. An event of that type in the same cycle leaves the count at 1.
- R8: A read request sets `regRdValid` high in the next cycle only, with `regRdata` holding the register value from the cycle of the request. Offsets other than 0x0, 0x4, 0x8 and 0xC read as zero.
- R9: Writes to offset 0xC and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sbeEvt | input | 1 | Correctable error reported this cycle |
| dbeEvt | input | 1 | Uncorrectable error reported this cycle |
| errAddr | input | ERR_AW | Address of the access that produced the report |
| regAddr | input | REG_AW | Byte offset of the register access |
| regWrite | input | 1 | Write request |
| regRead | input | 1 | Read request |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid with regRdValid |
| regRdValid | output | 1 | Read data valid, one cycle after regRead |
| irq | output | 1 | Interrupt, high while the interrupt status is set |

## Verification
The bench drives counts past their top to catch a counter that saturates at 15 or does not return to zero. It lands a status clear, or a count clear, in the same cycle as an event: a design that gave the clear priority would lose the event and read back 0. Both error types arrive together to expose a design that counts only one of them, and the bench writes to the address register, to unmapped offsets and to the status word with bit 0 clear, where a loose address decode would corrupt state or return stray data.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

  localparam int NUM_KINDS = 2;   // index 0: single-bit, index 1: double-bit

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_SBE_CNT,
    SEL_DBE_CNT,
    SEL_ADDR
  } rdSel_e;

  typedef struct packed {
    logic                 clrStatus;
    logic [NUM_KINDS-1:0] clrCnt;
    logic                 rdEn;
    rdSel_e               rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/ecc_stat_ctrl.sv
module ecc_stat_ctrl
  import ecc_stat_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [DATA_W-1:0] regWdata,
  output ctrlStrobe_t       strb
);

  localparam logic [REG_AW-1:0] OFS_STATUS = REG_AW'(4'h0);
  localparam logic [REG_AW-1:0] OFS_SBE    = REG_AW'(4'h4);
  localparam logic [REG_AW-1:0] OFS_DBE    = REG_AW'(4'h8);
  localparam logic [REG_AW-1:0] OFS_ADDR   = REG_AW'(4'hC);

  logic hitStatus, hitSbe, hitDbe, hitAddr;

  always_comb begin
    hitStatus = (regAddr == OFS_STATUS);
    hitSbe    = (regAddr == OFS_SBE);
    hitDbe    = (regAddr == OFS_DBE);
    hitAddr   = (regAddr == OFS_ADDR);
  end

  always_comb begin
    strb           = '0;
    strb.rdSel     = SEL_NONE;
    strb.clrStatus = regWrite && hitStatus && regWdata[0];
    strb.clrCnt[0] = regWrite && hitSbe;
    strb.clrCnt[1] = regWrite && hitDbe;
    strb.rdEn      = regRead;
    if (hitStatus)   strb.rdSel = SEL_STATUS;
    else if (hitSbe) strb.rdSel = SEL_SBE_CNT;
    else if (hitDbe) strb.rdSel = SEL_DBE_CNT;
    else if (hitAddr) strb.rdSel = SEL_ADDR;
  end

endmodule

// File: rtl/ecc_stat_cnt.sv
module ecc_stat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evt,
  input  logic             clrCnt,
  input  logic             clrFlag,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      // clear first, then count: wraps modulo 2**CNT_W
      if (clrCnt || evt)
        cnt <= (clrCnt ? '0 : cnt) + CNT_W'(evt);
      if (evt)
        flag <= 1'b1;
      else if (clrFlag)
        flag <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_stat_dp.sv
module ecc_stat_dp
  import ecc_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ERR_AW = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_KINDS-1:0] evt,
  input  logic [ERR_AW-1:0] errAddr,
  input  ctrlStrobe_t       strb,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRdValid,
  output logic              irq
);

  logic [NUM_KINDS-1:0][CNT_W-1:0] cntVal;
  logic [NUM_KINDS-1:0]            flagVal;
  logic                            irqQ;
  logic [ERR_AW-1:0]               lastAddr;
  logic [DATA_W-1:0]               rdWord;

  for (genvar g = 0; g < NUM_KINDS; g++) begin : gen_kind
    ecc_stat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .evt     (evt[g]),
      .clrCnt  (strb.clrCnt[g]),
      .clrFlag (strb.clrStatus),
      .cnt     (cntVal[g]),
      .flag    (flagVal[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ     <= 1'b0;
      lastAddr <= '0;
    end else begin
      if (|evt)
        irqQ <= 1'b1;
      else if (strb.clrStatus)
        irqQ <= 1'b0;
      if (|evt)
        lastAddr <= errAddr;
    end
  end

  always_comb begin
    rdWord = '0;
    unique case (strb.rdSel)
      SEL_STATUS:  rdWord = DATA_W'({irqQ, flagVal});
      SEL_SBE_CNT: rdWord = DATA_W'(cntVal[0]);
      SEL_DBE_CNT: rdWord = DATA_W'(cntVal[1]);
      SEL_ADDR:    rdWord = DATA_W'(lastAddr);
      default:     rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata   <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= strb.rdEn;
      if (strb.rdEn)
        regRdata <= rdWord;
    end
  end

  assign irq = irqQ;

endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_stat_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int DATA_W = 32,
  parameter int ERR_AW = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sbeEvt,
  input  logic              dbeEvt,
  input  logic [ERR_AW-1:0] errAddr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRdValid,
  output logic              irq
);

  ctrlStrobe_t strb;

  ecc_stat_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_ctrl (
    .regAddr  (regAddr),
    .regWrite (regWrite),
    .regRead  (regRead),
    .regWdata (regWdata),
    .strb     (strb)
  );

  ecc_stat_dp #(.DATA_W(DATA_W), .ERR_AW(ERR_AW), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .evt        ({dbeEvt, sbeEvt}),
    .errAddr    (errAddr),
    .strb       (strb),
    .regRdata   (regRdata),
    .regRdValid (regRdValid),
    .irq        (irq)
  );

endmodule

// File: rtl/ecc_err_status_chk.sv
module ecc_err_status_chk #(
  parameter int REG_AW = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sbeEvt,
  input logic              dbeEvt,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrite,
  input logic              regRead,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              regRdValid,
  input logic              irq
);

  localparam logic [REG_AW-1:0] A0 = REG_AW'(4'h0);
  localparam logic [REG_AW-1:0] A4 = REG_AW'(4'h4);
  localparam logic [REG_AW-1:0] A8 = REG_AW'(4'h8);
  localparam logic [REG_AW-1:0] AC = REG_AW'(4'hC);

  // R2
  evt_sets_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sbeEvt || dbeEvt) |=> irq);

  // R2
  irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(sbeEvt || dbeEvt));

  // R6
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == A0 && regWdata[0] && !sbeEvt && !dbeEvt) |=> !irq);

  // R8
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRead |=> regRdValid);

  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRead |=> !regRdValid);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr != A0 && regAddr != A4 && regAddr != A8 && regAddr != AC)
      |=> (regRdata == '0));

endmodule

bind ecc_err_status ecc_err_status_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sbeEvt     (sbeEvt),
  .dbeEvt     (dbeEvt),
  .regAddr    (regAddr),
  .regWrite   (regWrite),
  .regRead    (regRead),
  .regWdata   (regWdata),
  .regRdata   (regRdata),
  .regRdValid (regRdValid),
  .irq        (irq)
);

// File: tb/ecc_err_status_tb.sv
module ecc_err_status_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sbeEvt = 1'b0, dbeEvt = 1'b0;
  logic [31:0] errAddr = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrite = 1'b0, regRead = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRdValid, irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // bench model
  bit       mSbe, mDbe, mIrq;
  bit [3:0] mSbeCnt, mDbeCnt;
  bit [31:0] mAddr;

  always #2 clk = ~clk;

  ecc_err_status u_dut (
    .clk(clk), .rstN(rstN), .sbeEvt(sbeEvt), .dbeEvt(dbeEvt), .errAddr(errAddr),
    .regAddr(regAddr), .regWrite(regWrite), .regRead(regRead), .regWdata(regWdata),
    .regRdata(regRdata), .regRdValid(regRdValid), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [3:0] a);
    case (a)
      4'h0:    return {29'd0, mIrq, mDbe, mSbe};
      4'h4:    return {28'd0, mSbeCnt};
      4'h8:    return {28'd0, mDbeCnt};
      4'hC:    return mAddr;
      default: return 32'd0;
    endcase
  endfunction

  function automatic void modelStep(input bit s, input bit d, input logic [31:0] ea,
                                    input bit wr, input logic [3:0] a, input logic [31:0] wd);
    bit clrS, clr4, clr8;
    clrS = wr && a == 4'h0 && wd[0];
    clr4 = wr && a == 4'h4;
    clr8 = wr && a == 4'h8;
    if (clrS) begin mSbe = 0; mDbe = 0; mIrq = 0; end
    if (s) begin mSbe = 1; mIrq = 1; end
    if (d) begin mDbe = 1; mIrq = 1; end
    if (clr4) mSbeCnt = 0;
    if (clr8) mDbeCnt = 0;
    mSbeCnt = mSbeCnt + 4'(s);
    mDbeCnt = mDbeCnt + 4'(d);
    if (s || d) mAddr = ea;
  endfunction

  // one clock cycle; inputs driven at negedge, outputs checked at next negedge
  task automatic cyc(input string req, input bit s, input bit d, input logic [31:0] ea,
                     input bit wr, input bit rd, input logic [3:0] a, input logic [31:0] wd);
    logic [31:0] expData;
    sbeEvt = s; dbeEvt = d; errAddr = ea;
    regWrite = wr; regRead = rd; regAddr = a; regWdata = wd;
    expData = expRead(a);
    @(posedge clk);
    modelStep(s, d, ea, wr, a, wd);
    @(negedge clk);
    sbeEvt = 0; dbeEvt = 0; regWrite = 0; regRead = 0;
    check({req, " R8 valid"}, 32'(regRdValid), 32'(rd));
    if (rd) check(req, regRdata, expData);
    check({req, " R2 irq"}, 32'(irq), 32'(mIrq));
  endtask

  task automatic rd(input string req, input logic [3:0] a);
    cyc(req, 0, 0, 32'd0, 0, 1, a, 32'd0);
  endtask

  task automatic wr(input string req, input logic [3:0] a, input logic [31:0] wd);
    cyc(req, 0, 0, 32'd0, 1, 0, a, wd);
  endtask

  task automatic readAll(input string req);
    rd({req, " status"}, 4'h0);
    rd({req, " sbe count"}, 4'h4);
    rd({req, " dbe count"}, 4'h8);
    rd({req, " address"}, 4'hC);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 valid", 32'(regRdValid), 32'd0);
    readAll("R1");

    // R2 single and double flags
    cyc("R2 sbe", 1, 0, 32'h1000, 0, 0, 4'h0, 0);
    rd("R2 status after sbe", 4'h0);
    cyc("R2 dbe", 0, 1, 32'h2000, 0, 0, 4'h0, 0);
    rd("R2 status after dbe", 4'h0);

    // R6 clear with bit0 low does nothing, with bit0 high clears
    wr("R6 nop write", 4'h0, 32'hFFFF_FFFE);
    rd("R6 after nop write", 4'h0);
    wr("R6 clear", 4'h0, 32'h1);
    rd("R6 after clear", 4'h0);
    // R6 clear racing an event
    cyc("R6 clear plus event", 1, 0, 32'h3000, 1, 0, 4'h0, 32'h1);
    rd("R6 event wins", 4'h0);

    // R3 wrap of single-bit count
    wr("R7 zero sbe", 4'h4, 32'h0);
    for (int i = 0; i < 16; i++) cyc("R3 fill", 1, 0, 32'h100 + i, 0, 0, 4'h0, 0);
    rd("R3 wrapped to zero", 4'h4);
    cyc("R3 one more", 1, 0, 32'h200, 0, 0, 4'h0, 0);
    rd("R3 after wrap", 4'h4);

    // R4 double-bit count independent
    for (int i = 0; i < 17; i++) cyc("R4 fill", 0, 1, 32'h400 + i, 0, 0, 4'h0, 0);
    rd("R4 wrapped count", 4'h8);
    rd("R4 sbe untouched", 4'h4);

    // R5 both at once
    cyc("R5 both", 1, 1, 32'hDEAD_BEEF, 0, 0, 4'h0, 0);
    readAll("R5");

    // R7 count clear racing an event
    cyc("R7 clear plus event", 0, 1, 32'h5000, 1, 0, 4'h8, 32'h0);
    rd("R7 dbe is one", 4'h8);
    wr("R7 clear sbe", 4'h4, 32'hFFFF_FFFF);
    rd("R7 sbe is zero", 4'h4);

    // R9 writes to address and unmapped offsets
    wr("R9 addr write", 4'hC, 32'h1234_5678);
    wr("R9 unmapped write", 4'h2, 32'hFFFF_FFFF);
    wr("R9 unmapped write", 4'hE, 32'hFFFF_FFFF);
    readAll("R9");
    // R8 unmapped reads
    rd("R8 unmapped 0x2", 4'h2);
    rd("R8 unmapped 0xF", 4'hF);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit s, d, w, r;
      logic [3:0] a;
      logic [31:0] wd;
      s = ($urandom % 4) == 0;
      d = ($urandom % 6) == 0;
      w = ($urandom % 8) == 0;
      r = ($urandom % 2) == 0;
      a = 4'($urandom);
      if ($urandom % 3 != 0) a = {a[3:2], 2'b00};
      wd = $urandom;
      cyc("R5 random", s, d, $urandom, w, r, a, wd);
    end
    readAll("R3 R4 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule